// File: doc/BRIEF.md
# Rounding Serial Output Formatter

This block sits at the output of a decimating filter. It accepts a 32-bit two's complement result with a one-cycle valid strobe and turns it into a serial word of programmable length. Before serialisation the value may be doubled with saturation, then cut to the selected width by truncation or by rounding with saturation. It may then be recoded to offset binary. The formatted word is shifted out on a single data line, least or most significant bit first. Each bit is held for a programmable number of fast clock cycles.

Two 8-bit configuration inputs control the block. They are sampled only when a word is accepted, so firmware may rewrite them while a word is being sent. A bit clock and a frame pulse go out with the data. A result that arrives while the serializer is busy is dropped and reported with a one-cycle overrun pulse.

Top module: `ofmt_serializer`

## Requirements
- R1: The output width is taken from fmtCfg[4:0]. Code 0 selects 32 bits, codes 8 to 31 select that many bits, and the invalid codes 1 to 7 act as 8 bits.
- R2: With fmtCfg[5]=0 (truncate), the word is the upper W bits of the value, so the value is floored toward minus infinity.
- R3: With fmtCfg[5]=1 (round), half of one kept LSB is added before the cut. A result above the largest positive W-bit value saturates to that value.
- R4: With fmtCfg[7]=1 the input is doubled before rounding or truncation. Results outside the 32-bit range saturate to 0x7FFFFFFF or 0x80000000.
- R5: With fmtCfg[6]=1 the output is offset binary: bit W-1 of the formatted word is inverted. With fmtCfg[6]=0 it stays two's complement.
- R6: timCfg[5]=1 sends bit W-1 first, and timCfg[5]=0 sends bit 0 first.
- R7: Each bit is held on serOut for D fast cycles, where D is timCfg[4:0] and code 0 means 32. bitClk is high for the first ceil(D/2) cycles of every bit period and low for the rest.
- R8: frameOut is high for the whole first bit period of each word and low otherwise.
- R9: The first bit appears in the cycle after the clock edge that accepts dataValid. After W·D cycles the block is idle. While idle, serOut, bitClk and frameOut are low.
- R10: A dataValid that comes while a word is being shifted is dropped and does not disturb that word. overrun is high for exactly the one cycle after it.
- R11: Both configuration inputs are sampled when a word is accepted. Changes to them during shifting have no effect on that word.
- R12: While rstN is low, all outputs are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | 32 | Two's complement filter result |
| dataValid | input | 1 | One-cycle strobe qualifying dataIn |
| fmtCfg | input | 8 | [4:0] width code, [5] round, [6] offset binary, [7] gain of two |
| timCfg | input | 8 | [4:0] cycles per bit, [5] MSB first, [7:6] ignored |
| serOut | output | 1 | Serial data |
| bitClk | output | 1 | Output bit clock |
| frameOut | output | 1 | High during the first bit of a word |
| overrun | output | 1 | One-cycle pulse after a dropped word |

## Verification
The formatting path is tested with values chosen so that each control gives a different answer from its neighbours:
- A value sitting exactly at a half LSB gives a different word when truncated than when rounded, for both signs.
- A full-scale positive value exposes missing saturation in rounding.
- Values near ±2^30 tell a saturating doubler from a wrapping one.
- A zero input under offset binary shows whether the right bit is flipped for a given width.

Serialisation is run at several widths and dividers, in both bit orders, with an odd divider and the code-0 divider, so that wrong hold counts, a wrong bitClk duty or a reversed order show up as a different received word. A word sent with an injected mid-word strobe and changed settings separates a dropped word from one that restarts or reformats.

// File: rtl/ofmt_pkg.sv
package ofmt_pkg;
  localparam int unsigned POS_W = 5;
  localparam int unsigned CODE_W = 5;

  typedef struct packed {
    logic             load;
    logic             active;
    logic [POS_W-1:0] bitPos;
  } ofmt_strb_t;

  // width code -> width minus one; 0 means full 32, invalid 1..7 act as 8
  function automatic logic [POS_W-1:0] widthLast(input logic [CODE_W-1:0] code);
    if (code == '0)          return 5'd31;
    else if (code < 5'd8)    return 5'd7;
    else                     return code - 5'd1;
  endfunction

  // divider code -> cycles minus one; 0 wraps to 31 (32 cycles)
  function automatic logic [POS_W-1:0] divLast(input logic [CODE_W-1:0] code);
    return code - 5'd1;
  endfunction
endpackage

// File: rtl/ofmt_datapath.sv
module ofmt_datapath
  import ofmt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ofmt_strb_t        strb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [7:0]        fmtCfg,
  output logic              serOut
);
  localparam int unsigned SUM_W = DATA_W + 1;
  localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_MAX = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] gained, rounded, shifted, masked, formatted, wordReg;
  logic [SUM_W-1:0]  half, sum;
  logic [POS_W-1:0]  wLast;
  logic [5:0]        drop;

  always_comb begin
    // saturating gain of two
    if (fmtCfg[7]) begin
      if (dataIn[DATA_W-1] != dataIn[DATA_W-2])
        gained = dataIn[DATA_W-1] ? NEG_MAX : POS_MAX;
      else
        gained = {dataIn[DATA_W-2:0], 1'b0};
    end else begin
      gained = dataIn;
    end

    wLast = widthLast(fmtCfg[4:0]);
    drop  = 6'd31 - {1'b0, wLast};

    // round: add half of the kept LSB, saturate on positive overflow
    half = (fmtCfg[5] && drop != 6'd0) ? (SUM_W'(1) << (drop - 6'd1)) : '0;
    sum  = {gained[DATA_W-1], gained} + half;
    rounded = (sum[SUM_W-1] != sum[SUM_W-2]) ? POS_MAX : sum[DATA_W-1:0];

    shifted   = DATA_W'($signed(rounded) >>> drop);
    masked    = shifted & ({DATA_W{1'b1}} >> drop);
    formatted = fmtCfg[6] ? (masked ^ (DATA_W'(1) << wLast)) : masked;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          wordReg <= '0;
    else if (strb.load) wordReg <= formatted;
  end

  assign serOut = strb.active & wordReg[strb.bitPos];
endmodule

// File: rtl/ofmt_ctrl.sv
module ofmt_ctrl
  import ofmt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        dataValid,
  input  logic [4:0]  widthCode,
  input  logic [7:0]  timCfg,
  output ofmt_strb_t  strb,
  output logic        bitStart,
  output logic        bitClk,
  output logic        frameOut,
  output logic        overrun
);
  logic             busy, msbLat;
  logic [POS_W-1:0] bitIdx, divCnt, wLast, dLast;
  logic             accept, lastDiv, lastBit;

  assign accept  = dataValid && !busy;
  assign lastDiv = divCnt == dLast;
  assign lastBit = bitIdx == wLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      msbLat  <= 1'b0;
      bitIdx  <= '0;
      divCnt  <= '0;
      wLast   <= '0;
      dLast   <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= dataValid && busy;
      if (accept) begin
        busy   <= 1'b1;
        bitIdx <= '0;
        divCnt <= '0;
        wLast  <= widthLast(widthCode);
        dLast  <= divLast(timCfg[4:0]);
        msbLat <= timCfg[5];
      end else if (busy) begin
        if (lastDiv) begin
          divCnt <= '0;
          if (lastBit) busy <= 1'b0;
          else         bitIdx <= bitIdx + 5'd1;
        end else begin
          divCnt <= divCnt + 5'd1;
        end
      end
    end
  end

  always_comb begin
    strb.load   = accept;
    strb.active = busy;
    strb.bitPos = msbLat ? (wLast - bitIdx) : bitIdx;
  end

  assign bitStart = busy && divCnt == '0;
  assign bitClk   = busy && divCnt <= (dLast >> 1);
  assign frameOut = busy && bitIdx == '0;
endmodule

// File: rtl/ofmt_serializer.sv
module ofmt_serializer
  import ofmt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] dataIn,
  input  logic        dataValid,
  input  logic [7:0]  fmtCfg,
  input  logic [7:0]  timCfg,
  output logic        serOut,
  output logic        bitClk,
  output logic        frameOut,
  output logic        overrun
);
  ofmt_strb_t strb;
  logic       busy, bitStart;

  ofmt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .dataValid(dataValid), .widthCode(fmtCfg[4:0]),
    .timCfg(timCfg), .strb(strb), .bitStart(bitStart), .bitClk(bitClk),
    .frameOut(frameOut), .overrun(overrun)
  );

  ofmt_datapath #(.DATA_W(32)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(dataIn),
    .fmtCfg(fmtCfg), .serOut(serOut)
  );

  assign busy = strb.active;
endmodule

// File: rtl/ofmt_checker.sv
module ofmt_checker (
  input logic clk,
  input logic rstN,
  input logic dataValid,
  input logic serOut,
  input logic bitClk,
  input logic frameOut,
  input logic overrun,
  input logic busy,
  input logic bitStart
);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!serOut && !bitClk && !frameOut));

  // R10
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && busy) |=> overrun);

  // R10
  overrun_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(dataValid && busy) |=> !overrun);

  // R7
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !bitStart) |-> $stable(serOut));

  // R8
  frame_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameOut) |-> (bitClk && bitStart));
endmodule

bind ofmt_serializer ofmt_checker u_chk (.*);

// File: tb/test_ofmt_serializer.sv
module test_ofmt_serializer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] dataIn = '0;
  logic        dataValid = 1'b0;
  logic [7:0]  fmtCfg = '0;
  logic [7:0]  timCfg = '0;
  logic        serOut, bitClk, frameOut, overrun;
  int          nChecks = 0, nFails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  ofmt_serializer i_ofmt_serializer (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .dataValid(dataValid),
    .fmtCfg(fmtCfg), .timCfg(timCfg), .serOut(serOut), .bitClk(bitClk),
    .frameOut(frameOut), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int widthOf(input logic [7:0] f);
    if (f[4:0] == 0) return 32;
    if (f[4:0] < 8) return 8;
    return int'(f[4:0]);
  endfunction

  function automatic int divOf(input logic [7:0] t);
    return (t[4:0] == 0) ? 32 : int'(t[4:0]);
  endfunction

  function automatic logic [31:0] model(input logic [31:0] d, input logic [7:0] f);
    int w = widthOf(f);
    longint v = longint'($signed(d));
    longint q, maxq;
    logic [31:0] r;
    if (f[7]) begin
      v = v * 2;
      if (v > 64'sd2147483647) v = 64'sd2147483647;
      if (v < -64'sd2147483648) v = -64'sd2147483648;
    end
    if (f[5] && w < 32) q = (v + (64'sd1 <<< (31 - w))) >>> (32 - w);
    else                q = v >>> (32 - w);
    maxq = (64'sd1 <<< (w - 1)) - 1;
    if (q > maxq) q = maxq;
    r = q[31:0];
    if (w < 32) r = r & ((32'd1 << w) - 32'd1);
    if (f[6]) r[w-1] = ~r[w-1];
    return r;
  endfunction

  // send one word and check every sample; injectAt >= 0 drives a second
  // strobe (with altered data and settings) at that sample index
  task automatic runWord(input logic [31:0] d, input logic [7:0] f, input logic [7:0] t,
                         input string req, input int injectAt);
    int w = widthOf(f);
    int dv = divOf(t);
    logic [31:0] exp = model(d, f);
    logic [31:0] rx = '0;
    int clkErr = 0, frmErr = 0, ovErr = 0, idx = 0;
    @(negedge clk);
    dataIn = d; fmtCfg = f; timCfg = t; dataValid = 1'b1;
    @(negedge clk);
    dataValid = 1'b0;
    for (int b = 0; b < w; b++) begin
      for (int c = 0; c < dv; c++) begin
        if (c == 0) begin
          if (t[5]) rx[w-1-b] = serOut;
          else      rx[b]     = serOut;
        end else if (serOut != (t[5] ? rx[w-1-b] : rx[b])) begin
          clkErr++;
        end
        if (bitClk != (c < (dv + 1) / 2)) clkErr++;
        if (frameOut != (b == 0)) frmErr++;
        if (overrun != (injectAt >= 0 && idx == injectAt + 1)) ovErr++;
        dataValid = 1'b0;
        if (idx == injectAt) begin
          dataValid = 1'b1; dataIn = ~d; fmtCfg = f ^ 8'hE5; timCfg = t ^ 8'h27;
        end
        idx++;
        @(negedge clk);
      end
    end
    dataValid = 1'b0;
    check(rx == exp, req, rx, exp);
    check(clkErr == 0, "R7 bit hold/bitClk", clkErr, 0);
    check(frmErr == 0, "R8 frame", frmErr, 0);
    check(ovErr == 0, "R10 overrun", ovErr, 0);
    check({serOut, bitClk, frameOut} == 3'b000, "R9 idle after word",
          {serOut, bitClk, frameOut}, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    // R12
    check({serOut, bitClk, frameOut, overrun} == 4'b0, "R12 reset outputs",
          {serOut, bitClk, frameOut, overrun}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({serOut, bitClk, frameOut, overrun} == 4'b0, "R9 idle after reset",
          {serOut, bitClk, frameOut, overrun}, 0);
  endtask

  task automatic testPlain();
    runWord(32'h1234_5678, 8'h00, 8'h21, "R1 32-bit msb-first", -1);
    check(model(32'h1234_5678, 8'h00) == 32'h1234_5678, "R1 model sanity",
          model(32'h1234_5678, 8'h00), 32'h1234_5678);
  endtask

  task automatic testTruncRound();
    runWord(32'h0180_0000, 8'h08, 8'h22, "R2 truncate positive half", -1);
    runWord(32'h0180_0000, 8'h28, 8'h22, "R3 round positive half", -1);
    runWord(32'hFE80_0000, 8'h08, 8'h21, "R2 truncate negative half", -1);
    runWord(32'hFE80_0000, 8'h28, 8'h21, "R3 round negative half", -1);
    runWord(32'h7FFF_FFFF, 8'h30, 8'h21, "R3 round saturates", -1);
  endtask

  task automatic testGain();
    runWord(32'h4000_0000, 8'h80, 8'h21, "R4 gain saturates positive", -1);
    runWord(32'h9000_0000, 8'h80, 8'h21, "R4 gain saturates negative", -1);
    runWord(32'hE123_4567, 8'h90, 8'h21, "R4 gain in range", -1);
  endtask

  task automatic testOffset();
    runWord(32'h0000_0000, 8'h4C, 8'h21, "R5 offset binary zero", -1);
    runWord(32'h8000_0000, 8'h4C, 8'h01, "R5 offset binary lsb-first", -1);
  endtask

  task automatic testOrderAndDiv();
    runWord(32'hA5C3_0000, 8'h0A, 8'h03, "R6 lsb-first d=3", -1);
    runWord(32'hA5C3_0000, 8'h0A, 8'h23, "R6 msb-first d=3", -1);
    runWord(32'h5A00_0000, 8'h08, 8'h20, "R7 divider code 0", -1);
  endtask

  task automatic testInvalidWidth();
    runWord(32'hC3FF_FFFF, 8'h03, 8'h22, "R1 invalid code acts as 8", -1);
  endtask

  task automatic testOverrun();
    runWord(32'h3C5A_0000, 8'h10, 8'h22, "R10 dropped word keeps data", 5);
    runWord(32'h6000_0000, 8'h2C, 8'h23, "R11 config change mid-word", 0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testPlain();
    testTruncRound();
    testGain();
    testOffset();
    testOrderAndDiv();
    testInvalidWidth();
    testOverrun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule